// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a supervisory counter that requests a chip reset when software stops servicing it. It counts ticks from one of two sources, chosen by a static select. One source is the tick of a dedicated slow oscillator. The other is the core's instruction clock, which does not count while the core is halted. Every timeout takes 256 ticks of the fixed base stage, multiplied by a power-of-two ratio. A 3-bit field in an 8-bit control register sets that ratio.

Three things restart the count: the asynchronous active-low reset, halt entry, and a software clear. A static option selects how software clears. In single mode one strobe is enough. In paired mode two separate strobes must both be seen, in either order, and each is remembered until it is used. The control register bits above the ratio field are free flags for software. A static enable turns the whole block off.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset the count is zero, `to_flag` and `timeout_pulse` are low, and `ctl_rdata` reads 0x07.
- R2: With N = `ctl_rdata[2:0]`, a timeout happens after exactly 256·2^N counted ticks from the last clear or timeout. N=0 gives 256 ticks and N=7 gives 32768 ticks.
- R3: A timeout drives `timeout_pulse` high for exactly one cycle and sets `to_flag`. The count then restarts from zero.
- R4: Bits 7..3 of the control register are read/write flags. Their values do not change the timeout period.
- R5: In single mode (`pair_mode`=0), one `clr_one` strobe restarts the count and clears `to_flag`. In this mode `clr_a` and `clr_b` have no effect.
- R6: In paired mode (`pair_mode`=1), the count clears only once both `clr_a` and `clr_b` have been seen, in either order or in the same cycle. In this mode `clr_one` has no effect.
- R7: In paired mode, a strobe that has been recorded is discarded when a clear or a timeout happens.
- R8: A `halt_enter` strobe restarts the count and clears `to_flag`.
- R9: With `src_sel`=1 a tick is counted every cycle, except while `halted` is high. With `src_sel`=0 only `slow_tick` cycles are counted, and `halted` has no effect.
- R10: With `en_opt`=0 no timeout is ever produced and `to_flag` stays low.
- R11: A clear that arrives in the cycle of the final tick wins, and no timeout is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| en_opt | input | 1 | Static enable option |
| pair_mode | input | 1 | Static option: 1 selects the two-strobe clear |
| src_sel | input | 1 | Static option: 1 selects the instruction clock, 0 selects the slow tick |
| slow_tick | input | 1 | One-cycle tick from the slow oscillator |
| halted | input | 1 | Core is halted |
| halt_enter | input | 1 | Strobe on halt entry |
| clr_one | input | 1 | Single-mode software clear strobe |
| clr_a | input | 1 | Paired-mode first clear strobe |
| clr_b | input | 1 | Paired-mode second clear strobe |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| timeout_pulse | output | 1 | One-cycle timeout (reset request) |
| to_flag | output | 1 | Time-out status flag |

## Verification
The hardest cases to reach are the timing races. One is a clear that lands exactly on the final tick before the wrap. The other is a paired-mode strobe whose partner arrives only after a timeout has discarded it. The bench reaches both from the ports alone. It keeps an exact tick count from each clear, places a strobe on a chosen cycle offset, and then measures how many cycles remain until the next pulse. A behavioural tick-counting model is also compared against the outputs on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Last prescaler count for ratio 1:2^n.
  function automatic int unsigned ratio_last(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction

  // Ticks per timeout for a base of 2^base_w and ratio 1:2^n.
  function automatic int unsigned period_ticks(input int unsigned base_w,
                                               input int unsigned n);
    return 32'd1 << (base_w + n);
  endfunction

endpackage

// File: rtl/wdt_chain.sv
module wdt_chain #(
  parameter int BASE_W = 8,
  parameter int SEL_W  = 3,
  localparam int PRE_W = (1 << SEL_W) - 1,
  localparam int CNT_W = BASE_W + PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             wrap_ev,
  output logic [CNT_W-1:0] cnt_vec
);
  import wdt_pkg::*;

  logic [BASE_W-1:0] base_q;
  logic [PRE_W-1:0]  pre_q;
  logic              base_wrap;
  logic              pre_done;

  assign base_wrap = tick & (&base_q);
  assign pre_done  = pre_q >= PRE_W'(ratio_last(int'(sel)));
  assign wrap_ev   = base_wrap & pre_done & ~clr;
  assign cnt_vec   = {pre_q, base_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (clr) begin
      base_q <= '0;
      pre_q  <= '0;
    end else if (tick) begin
      base_q <= base_q + BASE_W'(1);
      if (base_wrap) pre_q <= pre_done ? '0 : pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdt_clr_arb.sv
module wdt_clr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pair_mode,
  input  logic clr_one,
  input  logic clr_a,
  input  logic clr_b,
  input  logic halt_enter,
  input  logic wrap_ev,
  output logic clr_fire,
  output logic [1:0] pend
);
  logic pa_q, pb_q;
  logic sw_ok;

  assign sw_ok    = pair_mode ? ((pa_q | clr_a) & (pb_q | clr_b)) : clr_one;
  assign clr_fire = en & (sw_ok | halt_enter);
  assign pend     = {pa_q, pb_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else if (!en || !pair_mode || clr_fire || wrap_ev) begin
      pa_q <= 1'b0;
      pb_q <= 1'b0;
    end else begin
      pa_q <= pa_q | clr_a;
      pb_q <= pb_q | clr_b;
    end
  end
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int CTL_W  = 8,
  parameter int SEL_W  = 3,
  parameter int BASE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_opt,
  input  logic             pair_mode,
  input  logic             src_sel,
  input  logic             slow_tick,
  input  logic             halted,
  input  logic             halt_enter,
  input  logic             clr_one,
  input  logic             clr_a,
  input  logic             clr_b,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             timeout_pulse,
  output logic             to_flag
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam int CNT_W = BASE_W + PRE_W;
  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'((1 << SEL_W) - 1);

  logic [CTL_W-1:0] ctl_q;
  logic             tick_en;
  logic             clr_fire;
  logic             wrap_ev;
  logic [1:0]       pend;
  logic [CNT_W-1:0] chain_cnt;

  assign tick_en   = en_opt & (src_sel ? ~halted : slow_tick);
  assign ctl_rdata = ctl_q;

  wdt_clr_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_opt),
    .pair_mode  (pair_mode),
    .clr_one    (clr_one),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .halt_enter (halt_enter),
    .wrap_ev    (wrap_ev),
    .clr_fire   (clr_fire),
    .pend       (pend)
  );

  wdt_chain #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .clr     (clr_fire),
    .sel     (ctl_q[SEL_W-1:0]),
    .wrap_ev (wrap_ev),
    .cnt_vec (chain_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q         <= CTL_RST;
      timeout_pulse <= 1'b0;
      to_flag       <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      timeout_pulse <= wrap_ev;
      if (clr_fire)     to_flag <= 1'b0;
      else if (wrap_ev) to_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_prescaled_chk.sv
module wdt_prescaled_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_opt,
  input logic             pair_mode,
  input logic             src_sel,
  input logic             halted,
  input logic             halt_enter,
  input logic             clr_one,
  input logic             clr_b,
  input logic             timeout_pulse,
  input logic             to_flag,
  input logic             clr_fire,
  input logic             wrap_ev,
  input logic [1:0]       pend,
  input logic [CNT_W-1:0] chain_cnt
);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  p_flag_on_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (timeout_pulse && to_flag && chain_cnt == '0));

  p_single_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pair_mode && !clr_one && !halt_enter) |-> !clr_fire);

  p_pair_needs_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode && !clr_b && !pend[0] && !halt_enter) |-> !clr_fire);

  p_pend_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire || wrap_ev) |=> pend == 2'b00);

  p_halt_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_opt && halt_enter) |=> (chain_cnt == '0 && !to_flag));

  p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_opt && src_sel && halted && !clr_fire) |=> $stable(chain_cnt));

  p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_opt |=> !timeout_pulse);

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (!timeout_pulse && !to_flag && chain_cnt == '0));
endmodule

bind wdt_prescaled wdt_prescaled_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_opt        (en_opt),
  .pair_mode     (pair_mode),
  .src_sel       (src_sel),
  .halted        (halted),
  .halt_enter    (halt_enter),
  .clr_one       (clr_one),
  .clr_b         (clr_b),
  .timeout_pulse (timeout_pulse),
  .to_flag       (to_flag),
  .clr_fire      (clr_fire),
  .wrap_ev       (wrap_ev),
  .pend          (pend),
  .chain_cnt     (chain_cnt)
);

// File: tb/test_wdt_prescaled.sv
`timescale 1ns/1ps
module test_wdt_prescaled;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_opt = 1'b1, pair_mode = 1'b0, src_sel = 1'b1;
  logic slow_tick, halted = 1'b0, halt_enter = 1'b0;
  logic clr_one = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic timeout_pulse, to_flag;

  int tests = 0, fails = 0, cyc = 0;
  logic [1:0] sdiv = 2'd0;

  always #10 clk = ~clk;  // 50 MHz

  always @(negedge clk) sdiv <= sdiv + 2'd1;
  assign slow_tick = (sdiv == 2'd3);

  wdt_prescaled i_wdt_prescaled (
    .clk(clk), .rst_n(rst_n), .en_opt(en_opt), .pair_mode(pair_mode),
    .src_sel(src_sel), .slow_tick(slow_tick), .halted(halted),
    .halt_enter(halt_enter), .clr_one(clr_one), .clr_a(clr_a), .clr_b(clr_b),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .timeout_pulse(timeout_pulse), .to_flag(to_flag)
  );

  // Behavioural reference: total ticks since the last restart
  int   m_ticks;
  bit   m_pa, m_pb, m_flag, m_pulse;
  logic [7:0] m_ctl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ticks = 0; m_pa = 0; m_pb = 0; m_flag = 0; m_pulse = 0; m_ctl = 8'h07;
    end else begin
      bit tk, sw, clr, wrapped;
      int per;
      tk  = en_opt && (src_sel ? !halted : slow_tick);
      sw  = pair_mode ? ((m_pa || clr_a) && (m_pb || clr_b)) : clr_one;
      clr = en_opt && (sw || halt_enter);
      per = 256 * (1 << m_ctl[2:0]);
      m_pulse = 0;
      wrapped = 0;
      if (clr) begin
        m_ticks = 0; m_pa = 0; m_pb = 0; m_flag = 0;
      end else begin
        if (tk) begin
          if (m_ticks + 1 == per) begin
            m_ticks = 0; m_pulse = 1; m_flag = 1; m_pa = 0; m_pb = 0; wrapped = 1;
          end else m_ticks++;
        end
        if (!wrapped && pair_mode) begin
          m_pa = m_pa || clr_a;
          m_pb = m_pb || clr_b;
        end
      end
      if (!en_opt || !pair_mode) begin m_pa = 0; m_pb = 0; end
      if (ctl_we) m_ctl = ctl_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (timeout_pulse !== m_pulse || to_flag !== m_flag || ctl_rdata !== m_ctl) begin
        fails++;
        $display("FAIL model compare (R2 R3): pulse/flag/ctl got %0b/%0b/%h expected %0b/%0b/%h",
                 timeout_pulse, to_flag, ctl_rdata, m_pulse, m_flag, m_ctl);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected below 190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic run(input int k); repeat (k) step(); endtask

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    do begin step(); n++; end while (!timeout_pulse && n < 70000);
  endtask

  task automatic do_reset(input bit en, input bit pair, input bit src);
    rst_n = 1'b0; en_opt = en; pair_mode = pair; src_sel = src;
    run(3);
    rst_n = 1'b1;
    step();
  endtask

  task automatic hclear(); halt_enter = 1'b1; step(); halt_enter = 1'b0; endtask

  task automatic set_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v; step(); ctl_we = 1'b0;
    hclear();
  endtask

  initial begin
    int n;
    int pulses;
    // R1 reset state
    rst_n = 1'b0; run(2);
    check("R1 ctl reset", int'(ctl_rdata), 7);
    check("R1 flag reset", int'(to_flag), 0);
    check("R1 pulse reset", int'(timeout_pulse), 0);
    rst_n = 1'b1; step();

    // R2 / R3 basic period, single pulse, restart
    set_ctl(8'h00);
    measure(n); check("R2 period N=0", n, 256);
    check("R3 flag set", int'(to_flag), 1);
    step(); check("R3 pulse one cycle", int'(timeout_pulse), 0);
    measure(n); check("R3 restart from zero", n, 255);

    // R8 halt entry clears flag and count
    hclear(); check("R8 flag cleared", int'(to_flag), 0);
    run(100); hclear(); measure(n); check("R8 count cleared", n, 256);

    // R4 user flags
    set_ctl(8'hF8); check("R4 readback", int'(ctl_rdata), 248);
    measure(n); check("R4 period unchanged", n, 256);

    // R2 other ratios
    set_ctl(8'h01); measure(n); check("R2 period N=1", n, 512);
    set_ctl(8'h03); measure(n); check("R2 period N=3", n, 2048);
    set_ctl(8'h07); measure(n); check("R2 period N=7", n, 32768);

    // R5 single mode
    set_ctl(8'h00);
    run(100);
    clr_a = 1'b1; step(); clr_a = 1'b0;
    clr_b = 1'b1; step(); clr_b = 1'b0;
    measure(n); check("R5 pair strobes ignored", n, 154);
    clr_one = 1'b1; step(); clr_one = 1'b0;
    check("R5 clear drops flag", int'(to_flag), 0);
    measure(n); check("R5 single clear", n, 256);

    // R11 clear on the final tick
    run(255);
    clr_one = 1'b1; step(); clr_one = 1'b0;
    check("R11 no pulse", int'(timeout_pulse), 0);
    measure(n); check("R11 full period after", n, 256);

    // R9 instruction clock frozen while halted
    run(50); halted = 1'b1; run(100); halted = 1'b0;
    measure(n); check("R9 halt pauses count", n, 206);

    // R6 paired mode
    do_reset(1'b1, 1'b1, 1'b1);
    set_ctl(8'h00);
    run(99);
    clr_one = 1'b1; step(); clr_one = 1'b0;
    clr_a = 1'b1; step(); clr_a = 1'b0;
    run(49);
    clr_b = 1'b1; step(); clr_b = 1'b0;
    measure(n); check("R6 a then b clears", n, 256);
    check("R6 flag before clear", int'(to_flag), 1);
    run(10);
    clr_b = 1'b1; step(); clr_b = 1'b0;
    run(9);
    clr_a = 1'b1; step(); clr_a = 1'b0;
    check("R6 pair clear drops flag", int'(to_flag), 0);
    measure(n); check("R6 b then a clears", n, 256);
    run(5);
    clr_a = 1'b1; clr_b = 1'b1; step(); clr_a = 1'b0; clr_b = 1'b0;
    measure(n); check("R6 same cycle clears", n, 256);

    // R7 pending strobe discarded by timeout
    clr_a = 1'b1; step(); clr_a = 1'b0;
    measure(n); check("R7 lone a no clear", n, 255);
    run(10);
    clr_b = 1'b1; step(); clr_b = 1'b0;
    measure(n); check("R7 stale a discarded", n, 245);

    // R9 slow oscillator source ignores halt
    do_reset(1'b1, 1'b0, 1'b0);
    set_ctl(8'h00);
    measure(n);
    measure(n); check("R9 slow tick period", n, 1024);
    halted = 1'b1;
    measure(n); check("R9 slow source runs in halt", n, 1024);
    halted = 1'b0;

    // R10 disabled
    do_reset(1'b0, 1'b0, 1'b1);
    set_ctl(8'h00);
    pulses = 0;
    for (int i = 0; i < 2000; i++) begin
      step();
      if (timeout_pulse) pulses++;
    end
    check("R10 no timeout", pulses, 0);
    check("R10 flag low", int'(to_flag), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule